// File: doc/BRIEF.md
# Serial-Bus Status Register Slave

This block is a two-wire serial bus slave that runs on a fast system clock. It passes SCL and SDA through synchronizers, detects START and STOP conditions on the synchronized lines, and answers the master by pulling SDA low through a single open-drain enable. It exposes one 8-bit word at a fixed word address. Seven bits of that word are live status inputs. The eighth bit returns the gate-drive feedback, and a bus write to it drives a gate request output, but only while the power-enable input is low. Any other word address reads as 0x00, and writes to those addresses are discarded.

A master selects the block with a 7-bit address. The upper four bits are the device type 1001b and the lower three bits must match the `dev_sel` pins. The address is followed by a R/W bit, where 1 means read. The active-low `cs_n` input must be low for the block to respond at all. A single write byte loads the internal word pointer. A repeated START with R/W set then reads from that pointer. Reads continue byte by byte while the master acknowledges and stop on a master NACK.

The block also contains an inactivity watchdog. Every acknowledge the slave drives restarts it, and so does every edge on `cs_n`. If neither happens within the interval chosen by `wd_sel`, the watchdog raises a sticky flag.

Top module: `stsreg_slave`

## Requirements
- R1: The block acknowledges an address byte only when its upper four bits are 1001b and bits 3..1 equal `dev_sel`. Any other address, including device type 1010b, gets no acknowledge.
- R2: While `cs_n` is high the block drives no acknowledge and no data, and SDA is released one clock after `cs_n` rises.
- R3: The word at address 0x02 reads as follows, bit 7 first: `card_good_n`, `sig_ready_n`, `gate_fb`, `in_reset`, `mon2_bad`, `mon1_bad`, `card5_ok`, `card3_ok`.
- R4: Every word address other than 0x02 reads as 0x00.
- R5: In a sequential read, the word pointer advances after each master ACK and wraps from 0xFF to 0x00. A master NACK ends the read, after which SDA stays released until the next START.
- R6: While `pwr_en` is low, a write to address 0x02 copies data bit 5 to `gate_req`. The other seven bits written have no effect on the status read back.
- R7: While `pwr_en` is high, writes leave `gate_req` unchanged. Writes to any address other than 0x02 also leave `gate_req` unchanged.
- R8: During a write, the slave acknowledges every data byte until STOP.
- R9: A random read works as follows: write the word address, issue a repeated START with R/W = 1, and data is returned from that address.
- R10: The watchdog flag sets about N cycles after the last restart. N is `WD_UNIT_CYCLES` times 1, 2 or 4 for `wd_sel` values 1, 2 and 3. With `wd_sel` = 0 the flag never sets.
- R11: The watchdog flag stays set until the slave drives an acknowledge or `cs_n` changes level. Either event clears the flag and restarts the count.
- R12: SDA is driven only as an active-low enable, and the enable rises only right after a detected SCL falling edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| scl_i | input | 1 | Serial clock line as seen at the pin |
| sda_i | input | 1 | Serial data line as seen at the pin |
| sda_oe | output | 1 | Pull SDA low when 1 |
| cs_n | input | 1 | Active-low chip select |
| dev_sel | input | 3 | Low three bits of the slave address |
| card_good_n | input | 1 | Status bit 7 |
| sig_ready_n | input | 1 | Status bit 6 |
| gate_fb | input | 1 | Status bit 5, live gate-drive state |
| in_reset | input | 1 | Status bit 4 |
| mon2_bad | input | 1 | Status bit 3 |
| mon1_bad | input | 1 | Status bit 2 |
| card5_ok | input | 1 | Status bit 1 |
| card3_ok | input | 1 | Status bit 0 |
| pwr_en | input | 1 | When high, blocks software control of the gate bit |
| wd_sel | input | 2 | Watchdog interval: 0 off, 1 x1, 2 x2, 3 x4 |
| gate_req | output | 1 | Software gate request bit |
| wd_expired | output | 1 | Sticky watchdog timeout flag |

## Verification
The embedded assertions check four rules on every cycle. SDA is released one cycle after chip select goes high. The SDA enable only rises after an SCL falling edge. The gate request never changes unless power-enable was low one cycle earlier. The watchdog flag is clear after every restart and never rises with the watchdog off. The directed scenarios cover what depends on whole transfers: address filtering, the bit order of the status word, zero reads elsewhere, pointer wrap in sequential reads, acknowledges on every write byte, the repeated-START random read, and the exact length of each watchdog interval.

// File: rtl/stsreg_pkg.sv
package stsreg_pkg;
  localparam int BYTE_W = 8;
  localparam int BITC_W = 4;

  typedef enum logic [2:0] {
    EN_IDLE,
    EN_DEV,
    EN_WORD,
    EN_WDAT,
    EN_ACK,
    EN_RDAT,
    EN_MACK
  } eng_st_t;
endpackage

// File: rtl/sb_sync.sv
module sb_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev
);
  logic [STAGES-1:0] scl_pipe;
  logic [STAGES-1:0] sda_pipe;
  logic scl_q, sda_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          scl_pipe <= '1;
          sda_pipe <= '1;
        end else begin
          scl_pipe <= scl_i;
          sda_pipe <= sda_i;
        end
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          scl_pipe <= '1;
          sda_pipe <= '1;
        end else begin
          scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
          sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
        end
      end
    end
  endgenerate

  assign scl_s = scl_pipe[STAGES-1];
  assign sda_s = sda_pipe[STAGES-1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s;
      sda_q <= sda_s;
    end
  end

  assign scl_rise = scl_s & ~scl_q;
  assign scl_fall = ~scl_s & scl_q;
  assign start_ev = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_ev  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/sb_engine.sv
module sb_engine
  import stsreg_pkg::*;
#(
  parameter logic [3:0] DEV_TYPE = 4'b1001
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_ev,
  input  logic              stop_ev,
  input  logic              sda_s,
  input  logic              cs_n,
  input  logic [2:0]        addr_sel,
  input  logic [BYTE_W-1:0] rd_data,
  output logic [BYTE_W-1:0] word_addr,
  output logic              wr_stb,
  output logic [BYTE_W-1:0] wr_addr,
  output logic [BYTE_W-1:0] wr_data,
  output logic              ack_ev,
  output logic              sda_oe
);
  eng_st_t           st, after;
  logic [BITC_W-1:0] bitc;
  logic [BYTE_W-1:0] rx, tx;
  logic              mack;
  logic              dev_hit;

  assign dev_hit = (rx[7:4] == DEV_TYPE) && (rx[3:1] == addr_sel);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= EN_IDLE;
      after     <= EN_IDLE;
      bitc      <= '0;
      rx        <= '0;
      tx        <= '0;
      mack      <= 1'b0;
      word_addr <= '0;
      wr_stb    <= 1'b0;
      wr_addr   <= '0;
      wr_data   <= '0;
      ack_ev    <= 1'b0;
      sda_oe    <= 1'b0;
    end else begin
      ack_ev <= 1'b0;
      wr_stb <= 1'b0;
      if (cs_n) begin
        st     <= EN_IDLE;
        sda_oe <= 1'b0;
      end else if (start_ev) begin
        st     <= EN_DEV;
        bitc   <= '0;
        sda_oe <= 1'b0;
      end else if (stop_ev) begin
        st     <= EN_IDLE;
        sda_oe <= 1'b0;
      end else begin
        case (st)
          EN_DEV, EN_WORD, EN_WDAT: begin
            if (scl_rise && bitc != 4'd8) begin
              rx   <= {rx[BYTE_W-2:0], sda_s};
              bitc <= bitc + 4'd1;
            end else if (scl_fall && bitc == 4'd8) begin
              if (st == EN_DEV) begin
                if (dev_hit) begin
                  sda_oe <= 1'b1;
                  ack_ev <= 1'b1;
                  st     <= EN_ACK;
                  after  <= rx[0] ? EN_RDAT : EN_WORD;
                end else begin
                  st <= EN_IDLE;
                end
              end else if (st == EN_WORD) begin
                word_addr <= rx;
                sda_oe    <= 1'b1;
                ack_ev    <= 1'b1;
                st        <= EN_ACK;
                after     <= EN_WDAT;
              end else begin
                wr_stb    <= 1'b1;
                wr_addr   <= word_addr;
                wr_data   <= rx;
                word_addr <= word_addr + 8'd1;
                sda_oe    <= 1'b1;
                ack_ev    <= 1'b1;
                st        <= EN_ACK;
                after     <= EN_WDAT;
              end
            end
          end
          EN_ACK: begin
            if (scl_fall) begin
              bitc <= '0;
              st   <= after;
              if (after == EN_RDAT) begin
                tx     <= rd_data;
                sda_oe <= ~rd_data[BYTE_W-1];
              end else begin
                sda_oe <= 1'b0;
              end
            end
          end
          EN_RDAT: begin
            if (scl_rise) begin
              tx   <= tx << 1;
              bitc <= bitc + 4'd1;
            end else if (scl_fall) begin
              if (bitc == 4'd8) begin
                sda_oe <= 1'b0;
                st     <= EN_MACK;
              end else begin
                sda_oe <= ~tx[BYTE_W-1];
              end
            end
          end
          EN_MACK: begin
            if (scl_rise) begin
              mack <= ~sda_s;
              if (!sda_s) word_addr <= word_addr + 8'd1;
            end else if (scl_fall) begin
              if (mack) begin
                tx     <= rd_data;
                sda_oe <= ~rd_data[BYTE_W-1];
                bitc   <= '0;
                st     <= EN_RDAT;
              end else begin
                st <= EN_IDLE;
              end
            end
          end
          default: begin
            sda_oe <= 1'b0;
          end
        endcase
      end
    end
  end

  // R2
  cs_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> !sda_oe);

  // R12
  oe_after_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> $past(scl_fall));
endmodule

// File: rtl/sb_watchdog.sv
module sb_watchdog #(
  parameter int UNIT_CYCLES = 200_000_000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       kick,
  input  logic [1:0] sel,
  output logic       expired
);
  localparam int MAX_CYC = UNIT_CYCLES * 4;
  localparam int CW      = $clog2(MAX_CYC + 1);

  logic [CW-1:0] cnt;
  logic [CW-1:0] limit;

  always_comb begin
    case (sel)
      2'd1:    limit = CW'(UNIT_CYCLES);
      2'd2:    limit = CW'(UNIT_CYCLES * 2);
      2'd3:    limit = CW'(MAX_CYC);
      default: limit = CW'(MAX_CYC);
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt     <= '0;
      expired <= 1'b0;
    end else if (kick) begin
      cnt     <= '0;
      expired <= 1'b0;
    end else if (sel == 2'd0) begin
      cnt <= '0;
    end else if (!expired) begin
      if (cnt >= limit - CW'(1)) expired <= 1'b1;
      else                       cnt <= cnt + CW'(1);
    end
  end

  // R11
  kick_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    kick |=> !expired);

  // R10
  off_never_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(expired) |-> $past(sel) != 2'd0);
endmodule

// File: rtl/stsreg_slave.sv
module stsreg_slave
  import stsreg_pkg::*;
#(
  parameter int          WD_UNIT_CYCLES = 200_000_000,
  parameter int          SYNC_STAGES    = 2,
  parameter logic [3:0]  DEV_TYPE       = 4'b1001,
  parameter logic [7:0]  STS_WORD       = 8'h02
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe,
  input  logic       cs_n,
  input  logic [2:0] dev_sel,
  input  logic       card_good_n,
  input  logic       sig_ready_n,
  input  logic       gate_fb,
  input  logic       in_reset,
  input  logic       mon2_bad,
  input  logic       mon1_bad,
  input  logic       card5_ok,
  input  logic       card3_ok,
  input  logic       pwr_en,
  input  logic [1:0] wd_sel,
  output logic       gate_req,
  output logic       wd_expired
);
  localparam int GATE_BIT = 5;

  logic scl_s, sda_s, scl_rise, scl_fall, start_ev, stop_ev;
  logic [BYTE_W-1:0] word_addr, wr_addr, wr_data, rd_data, status_w;
  logic wr_stb, ack_ev, cs_q, cs_edge;

  sb_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_ev(start_ev), .stop_ev(stop_ev)
  );

  assign status_w = {card_good_n, sig_ready_n, gate_fb, in_reset,
                     mon2_bad, mon1_bad, card5_ok, card3_ok};
  assign rd_data  = (word_addr == STS_WORD) ? status_w : '0;

  sb_engine #(.DEV_TYPE(DEV_TYPE)) u_eng (
    .clk(clk), .rst_n(rst_n), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_ev(start_ev), .stop_ev(stop_ev), .sda_s(sda_s), .cs_n(cs_n),
    .addr_sel(dev_sel), .rd_data(rd_data), .word_addr(word_addr),
    .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data),
    .ack_ev(ack_ev), .sda_oe(sda_oe)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gate_req <= 1'b0;
      cs_q     <= 1'b1;
    end else begin
      cs_q <= cs_n;
      if (wr_stb && wr_addr == STS_WORD && !pwr_en)
        gate_req <= wr_data[GATE_BIT];
    end
  end

  assign cs_edge = cs_n ^ cs_q;

  sb_watchdog #(.UNIT_CYCLES(WD_UNIT_CYCLES)) u_wd (
    .clk(clk), .rst_n(rst_n), .kick(ack_ev | cs_edge), .sel(wd_sel),
    .expired(wd_expired)
  );

  // R7
  gate_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(gate_req) |-> !$past(pwr_en));
endmodule

// File: tb/stsreg_slave_test.sv
module stsreg_slave_test;
  localparam int Q = 8;
  localparam int WDU = 100;
  localparam logic [7:0] DW = 8'h9A;
  localparam logic [7:0] DR = 8'h9B;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1, cs_n = 1'b0;
  logic card_good_n = 1'b0, sig_ready_n = 1'b0, in_reset = 1'b0;
  logic mon2_bad = 1'b0, mon1_bad = 1'b0, card5_ok = 1'b0, card3_ok = 1'b0;
  logic pwr_en = 1'b0;
  logic [1:0] wd_sel = 2'd0;
  logic sda_oe, gate_req, wd_expired;
  wire  sda_line = sda_m & ~sda_oe;
  int checks = 0, errors = 0, oe_bad = 0;
  logic oe_prev = 1'b0;

  always #2 clk = ~clk;

  stsreg_slave #(.WD_UNIT_CYCLES(WDU)) uut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line), .sda_oe(sda_oe),
    .cs_n(cs_n), .dev_sel(3'b101), .card_good_n(card_good_n),
    .sig_ready_n(sig_ready_n), .gate_fb(gate_req), .in_reset(in_reset),
    .mon2_bad(mon2_bad), .mon1_bad(mon1_bad), .card5_ok(card5_ok),
    .card3_ok(card3_ok), .pwr_en(pwr_en), .wd_sel(wd_sel),
    .gate_req(gate_req), .wd_expired(wd_expired)
  );

  always @(negedge clk) begin
    if (rst_n && sda_oe != oe_prev && scl_m) oe_bad++;
    oe_prev <= sda_oe;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(Q);
    sda_m = 1'b0; tick(Q); scl_m = 1'b0; tick(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; tick(Q); scl_m = 1'b1; tick(Q); sda_m = 1'b1; tick(Q);
  endtask

  task automatic put_bit(input logic b);
    sda_m = b; tick(Q); scl_m = 1'b1; tick(2 * Q); scl_m = 1'b0; tick(Q);
  endtask

  task automatic put_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) put_bit(b[i]);
    sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(Q);
    ack = ~sda_line; tick(Q); scl_m = 1'b0; tick(Q);
  endtask

  task automatic get_byte(input logic nack, output logic [7:0] d);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      tick(Q); scl_m = 1'b1; tick(Q); d[i] = sda_line; tick(Q); scl_m = 1'b0; tick(Q);
    end
    put_bit(nack);
  endtask

  task automatic read_at(input logic [7:0] wa, output logic [7:0] d);
    logic a;
    bus_start(); put_byte(DW, a); put_byte(wa, a);
    bus_start(); put_byte(DR, a); get_byte(1'b1, d); bus_stop();
  endtask

  task automatic write_at(input logic [7:0] wa, input logic [7:0] d, output logic all_ack);
    logic a1, a2, a3;
    bus_start(); put_byte(DW, a1); put_byte(wa, a2); put_byte(d, a3); bus_stop();
    all_ack = a1 & a2 & a3;
  endtask

  function automatic logic [7:0] sts();
    return {card_good_n, sig_ready_n, gate_req, in_reset, mon2_bad, mon1_bad, card5_ok, card3_ok};
  endfunction

  task automatic t_reset();
    check("reset sda_oe", sda_oe, 0);
    check("reset gate_req", gate_req, 0);
    check("reset wd_expired", wd_expired, 0);
  endtask

  task automatic t_addr();
    logic a;
    bus_start(); put_byte(DW, a); bus_stop();
    check("R1 matching address acked", a, 1);
    bus_start(); put_byte(8'h9E, a); bus_stop();
    check("R1 wrong select not acked", a, 0);
    bus_start(); put_byte(8'hAA, a); bus_stop();
    check("R1 memory type not acked", a, 0);
  endtask

  task automatic t_cs();
    logic a;
    cs_n = 1'b1;
    bus_start(); put_byte(DW, a); bus_stop();
    check("R2 no ack with cs_n high", a, 0);
    cs_n = 1'b0; tick(4);
  endtask

  task automatic t_status();
    logic [7:0] d;
    card_good_n = 1; sig_ready_n = 0; in_reset = 1; mon2_bad = 0;
    mon1_bad = 1; card5_ok = 0; card3_ok = 1;
    read_at(8'h02, d);
    check("R3 R9 status pattern A", d, sts());
    card_good_n = 0; sig_ready_n = 1; in_reset = 0; mon2_bad = 1;
    mon1_bad = 0; card5_ok = 1; card3_ok = 0;
    read_at(8'h02, d);
    check("R3 R9 status pattern B", d, sts());
    read_at(8'h05, d);
    check("R4 other address reads zero", d, 0);
  endtask

  task automatic t_seq();
    logic a;
    logic [7:0] d0, d1, d2, d3, dx;
    bus_start(); put_byte(DW, a); put_byte(8'hFF, a);
    bus_start(); put_byte(DR, a);
    get_byte(1'b0, d0); get_byte(1'b0, d1); get_byte(1'b0, d2); get_byte(1'b1, d3);
    check("R5 byte at FF", d0, 0);
    check("R5 wrap to 00", d1, 0);
    check("R5 byte at 02 after wrap", d3, sts());
    get_byte(1'b1, dx);
    check("R5 released after NACK", dx, 8'hFF);
    bus_stop();
    check("R5 byte at 01", d2, 0);
  endtask

  task automatic t_write();
    logic ok, a1, a2, a3, a4, a5;
    logic [7:0] d;
    pwr_en = 1'b0;
    bus_start(); put_byte(DW, a1); put_byte(8'h02, a2); put_byte(8'h20, a3);
    put_byte(8'h00, a4); put_byte(8'h55, a5); bus_stop();
    check("R8 every write byte acked", {a1, a2, a3, a4, a5}, 5'b11111);
    check("R6 gate set by bit5", gate_req, 1);
    write_at(8'h02, 8'hDF, ok);
    check("R6 gate cleared by bit5=0", gate_req, 0);
    read_at(8'h02, d);
    check("R6 other written bits ignored", d, sts());
    write_at(8'h03, 8'h20, ok);
    check("R7 other address leaves gate", gate_req, 0);
    pwr_en = 1'b1; tick(2);
    write_at(8'h02, 8'h20, ok);
    check("R7 write blocked with pwr_en high", gate_req, 0);
    check("R8 blocked write still acked", ok, 1);
    pwr_en = 1'b0;
  endtask

  task automatic cs_kick();
    cs_n = 1'b1; tick(2); cs_n = 1'b0;
  endtask

  task automatic t_wd();
    logic a;
    wd_sel = 2'd1; cs_kick();
    tick(90);  check("R10 x1 not yet expired", wd_expired, 0);
    tick(20);  check("R10 x1 expired", wd_expired, 1);
    tick(50);  check("R11 flag sticky", wd_expired, 1);
    cs_kick(); tick(2);
    check("R11 cleared by cs edge", wd_expired, 0);
    tick(120); check("R10 expired again", wd_expired, 1);
    bus_start(); put_byte(DW, a); bus_stop();
    check("R11 cleared by acknowledge", wd_expired, 0);
    wd_sel = 2'd2; cs_kick();
    tick(190); check("R10 x2 not yet expired", wd_expired, 0);
    tick(20);  check("R10 x2 expired", wd_expired, 1);
    wd_sel = 2'd3; cs_kick();
    tick(390); check("R10 x4 not yet expired", wd_expired, 0);
    tick(20);  check("R10 x4 expired", wd_expired, 1);
    wd_sel = 2'd0; cs_kick();
    tick(600); check("R10 off never expires", wd_expired, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog timeout actual=running expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    tick(6);
    rst_n = 1'b1;
    tick(4);
    t_reset();
    t_addr();
    t_cs();
    t_status();
    t_seq();
    t_write();
    t_wd();
    check("R12 SDA enable changed only with SCL low", oe_bad, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule